// File: doc/BRIEF.md
# Status Indicator LED Controller

This block turns a handful of control-register bits into drive levels for four status LEDs and one general-purpose select pin. Three of the LEDs are plain on/off lamps, each lit by its own bit. The first LED has three possible sources, in a fixed priority order. A steady-on bit wins over everything else. Below that, a blink bit makes the LED toggle at a rate set by a parameter. Below that, a mirror-enable bit makes the LED follow an external carrier-detect signal.

The register bits arrive on a write port: a one-cycle strobe qualifies a group of data inputs, and the block keeps its own copy of them. The carrier-detect input may be asynchronous, so it passes through a two-flop synchronizer before it is used. The select pin is driven to the inverse of its register bit. Because every stored bit clears to 0 on reset, the pin comes out of reset high.

The bus decode that produces the write strobe is outside this block, and so are the physical LED drivers.

Top module: `ledStatusCtl`

## Requirements
- R1: While reset is held and directly after it is released, all four LED outputs are 0 and `ifSelPin` is 1.
- R2: `ledOut[i]` drives LED number i+1. After a write, `ledOut[3:1]` equals the written `cfgLedOn[3:1]`, with each bit independent of the others and of every other input.
- R3: While the stored `cfgLedOn[0]` is 1, `ledOut[0]` is 1, whatever the blink bit, the mirror bit and the carrier input are.
- R4: While the stored blink bit is 1 and the stored `cfgLedOn[0]` is 0, `ledOut[0]` toggles every `HALF_PERIOD` clock cycles. This gives a 50% duty cycle from a free-running prescaler.
- R5: While blinking is selected, the carrier input has no effect on `ledOut[0]`. The LED still shows both levels, whether the carrier is held at 0 or at 1.
- R6: While only the mirror bit is set (steady-on and blink both 0), `ledOut[0]` follows `carrierIn`. A change on `carrierIn` reaches `ledOut[0]` on the second rising clock edge after it, and not on the first.
- R7: While the mirror bit is 0 and neither of the higher-priority sources is selected, `carrierIn` has no effect and `ledOut[0]` stays 0.
- R8: When steady-on, blink and mirror are all 0, `ledOut[0]` is 0.
- R9: After a write, `ifSelPin` is the inverse of the written `cfgIfSel`: high for 0, low for 1.
- R10: When `cfgWr` is 0, changes on the configuration data inputs leave every output unchanged. A write takes effect on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Write strobe for the configuration bits |
| cfgLedOn | input | 4 | Steady-on bits; bit i lights LED i+1 |
| cfgFlash | input | 1 | Blink bit for LED 1 |
| cfgCdEnable | input | 1 | Carrier-mirror enable for LED 1 |
| cfgIfSel | input | 1 | Select-pin control bit (pin level is its inverse) |
| carrierIn | input | 1 | Carrier-detect input, may be asynchronous |
| ledOut | output | 4 | LED drive lines, 1 = lit |
| ifSelPin | output | 1 | General-purpose select pin |

## Verification
The hardest situation to reach from the ports is blinking, because the prescaler runs freely and its phase cannot be seen or set from outside. The bench therefore measures blinking rather than predicting its phase. It waits for an edge on LED 1, then counts the cycles to the next edge, which must equal the half-period. It repeats this with the carrier held high and then held low, so that a design letting the carrier leak through would show a run of the wrong length or a level stuck at one value. The two-cycle synchronizer latency is pinned down by moving the carrier on a falling edge and sampling after each of the next two rising edges.

// File: rtl/ledCtlPkg.sv
package ledCtlPkg;

  localparam int LED_COUNT = 4;

  // Source that drives LED 1, chosen by priority in the control module
  typedef enum logic [1:0] {
    SRC_OFF     = 2'd0,
    SRC_STEADY  = 2'd1,
    SRC_BLINK   = 2'd2,
    SRC_CARRIER = 2'd3
  } led1Src_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LED_COUNT-1:1] steadyOn;
    led1Src_e             led1Src;
    logic                 pinLevel;
  } ledStrobes_t;

endpackage

// File: rtl/ledCtlControl.sv
module ledCtlControl
  import ledCtlPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [LED_COUNT-1:0] cfgLedOn,
  input  logic                 cfgFlash,
  input  logic                 cfgCdEnable,
  input  logic                 cfgIfSel,
  output ledStrobes_t          strobes
);

  logic [LED_COUNT-1:0] onReg;
  logic                 flashReg;
  logic                 cdEnReg;
  logic                 ifSelReg;

  // Configuration storage, loaded only on the write strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onReg    <= '0;
      flashReg <= 1'b0;
      cdEnReg  <= 1'b0;
      ifSelReg <= 1'b0;
    end else if (cfgWr) begin
      onReg    <= cfgLedOn;
      flashReg <= cfgFlash;
      cdEnReg  <= cfgCdEnable;
      ifSelReg <= cfgIfSel;
    end
  end

  // LED 1 source: steady over blink over carrier mirror
  always_comb begin
    strobes.steadyOn = onReg[LED_COUNT-1:1];
    strobes.pinLevel = ~ifSelReg;
    if (onReg[0])       strobes.led1Src = SRC_STEADY;
    else if (flashReg)  strobes.led1Src = SRC_BLINK;
    else if (cdEnReg)   strobes.led1Src = SRC_CARRIER;
    else                strobes.led1Src = SRC_OFF;
  end

endmodule

// File: rtl/ledCtlDatapath.sv
module ledCtlDatapath
  import ledCtlPkg::*;
#(
  parameter int HALF_PERIOD = 12_500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ledStrobes_t          strobes,
  input  logic                 carrierIn,
  output logic [LED_COUNT-1:0] ledOut,
  output logic                 ifSelPin
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  // Carrier synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= carrierIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b0;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  logic carrierSync;
  assign carrierSync = syncChain[SYNC_STAGES-1];

  // Free-running blink prescaler
  logic [CNT_W-1:0] preCnt;
  logic             blinkPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      blinkPhase <= 1'b0;
    end else if (preCnt == CNT_LAST) begin
      preCnt     <= '0;
      blinkPhase <= ~blinkPhase;
    end else begin
      preCnt     <= preCnt + 1'b1;
    end
  end

  // Output selection
  logic led1Level;

  always_comb begin
    unique case (strobes.led1Src)
      SRC_STEADY:  led1Level = 1'b1;
      SRC_BLINK:   led1Level = blinkPhase;
      SRC_CARRIER: led1Level = carrierSync;
      default:     led1Level = 1'b0;
    endcase
  end

  assign ledOut   = {strobes.steadyOn, led1Level};
  assign ifSelPin = strobes.pinLevel;

endmodule

// File: rtl/ledStatusCtl.sv
module ledStatusCtl
  import ledCtlPkg::*;
#(
  parameter int HALF_PERIOD = 12_500_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [LED_COUNT-1:0] cfgLedOn,
  input  logic                 cfgFlash,
  input  logic                 cfgCdEnable,
  input  logic                 cfgIfSel,
  input  logic                 carrierIn,
  output logic [LED_COUNT-1:0] ledOut,
  output logic                 ifSelPin
);

  ledStrobes_t strobes;

  ledCtlControl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .cfgLedOn    (cfgLedOn),
    .cfgFlash    (cfgFlash),
    .cfgCdEnable (cfgCdEnable),
    .cfgIfSel    (cfgIfSel),
    .strobes     (strobes)
  );

  ledCtlDatapath #(
    .HALF_PERIOD (HALF_PERIOD),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .carrierIn (carrierIn),
    .ledOut    (ledOut),
    .ifSelPin  (ifSelPin)
  );

endmodule

// File: rtl/ledStatusChk.sv
module ledStatusChk
  import ledCtlPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWr,
  input logic [LED_COUNT-1:0] cfgLedOn,
  input logic                 cfgFlash,
  input logic                 cfgCdEnable,
  input logic                 cfgIfSel,
  input logic [LED_COUNT-1:0] ledOut,
  input logic                 ifSelPin
);

  // Shadow copy of the written configuration, kept from the port side
  logic [LED_COUNT-1:0] shOn;
  logic                 shFlash;
  logic                 shCd;
  logic                 shIf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shOn    <= '0;
      shFlash <= 1'b0;
      shCd    <= 1'b0;
      shIf    <= 1'b0;
    end else if (cfgWr) begin
      shOn    <= cfgLedOn;
      shFlash <= cfgFlash;
      shCd    <= cfgCdEnable;
      shIf    <= cfgIfSel;
    end
  end

  p_upper_leds_r2: assert property (@(posedge clk) disable iff (!rstN)
    ledOut[LED_COUNT-1:1] == shOn[LED_COUNT-1:1]);

  p_steady_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    shOn[0] |-> ledOut[0]);

  p_idle_dark_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!shOn[0] && !shFlash && !shCd) |-> !ledOut[0]);

  p_pin_inverse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ifSelPin == !shIf);

  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> ($stable(ledOut[LED_COUNT-1:1]) && $stable(ifSelPin)));

endmodule

bind ledStatusCtl ledStatusChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWr       (cfgWr),
  .cfgLedOn    (cfgLedOn),
  .cfgFlash    (cfgFlash),
  .cfgCdEnable (cfgCdEnable),
  .cfgIfSel    (cfgIfSel),
  .ledOut      (ledOut),
  .ifSelPin    (ifSelPin)
);

// File: tb/test_ledStatusCtl.sv
`timescale 1ns/1ps
module test_ledStatusCtl;

  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0;
  logic [3:0] cfgLedOn = '0;
  logic       cfgFlash = 1'b0;
  logic       cfgCdEnable = 1'b0;
  logic       cfgIfSel = 1'b0;
  logic       carrierIn = 1'b0;
  logic [3:0] ledOut;
  logic       ifSelPin;

  int nTests = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  ledStatusCtl #(.HALF_PERIOD(HP)) i_ledStatusCtl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgLedOn(cfgLedOn),
    .cfgFlash(cfgFlash), .cfgCdEnable(cfgCdEnable), .cfgIfSel(cfgIfSel),
    .carrierIn(carrierIn), .ledOut(ledOut), .ifSelPin(ifSelPin)
  );

  // Row: [12:9] on, [8] flash, [7] mirror, [6] sel bit, [5] carrier,
  //      [4:1] expected LEDs, [0] expected pin
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    13'b0000_0_0_0_0_0000_1,
    13'b0010_0_0_1_0_0010_0,
    13'b1100_0_0_0_0_1100_1,
    13'b0001_1_0_0_0_0001_1,
    13'b0001_0_1_0_0_0001_1,
    13'b0000_0_1_0_1_0001_1,
    13'b0000_0_1_1_0_0000_0,
    13'b0000_0_0_0_1_0000_1,
    13'b1111_1_1_1_1_1111_0,
    13'b1010_0_1_0_1_1011_1
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: leds/pin got %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [3:0] on, input logic fl, input logic cd, input logic sel);
    @(negedge clk);
    cfgLedOn = on; cfgFlash = fl; cfgCdEnable = cd; cfgIfSel = sel; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // Length of the next full run of LED 1, measured in clock cycles
  task automatic measureRun(output int len);
    logic last;
    int   guard;
    len = 0;
    guard = 0;
    @(negedge clk);
    last = ledOut[0];
    while (ledOut[0] == last && guard < 8 * HP) begin
      @(negedge clk); guard++;
    end
    last = ledOut[0];
    while (ledOut[0] == last && len < 8 * HP) begin
      @(negedge clk); len++;
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    int runLen;
    logic sawHigh;
    logic sawLow;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 during reset", {ledOut, ifSelPin}, 5'b0000_1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {ledOut, ifSelPin}, 5'b0000_1);

    // Vector table: R2 R3 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      carrierIn = VEC[i][5];
      writeCfg(VEC[i][12:9], VEC[i][8], VEC[i][7], VEC[i][6]);
      repeat (2) @(negedge clk);
      check($sformatf("table row %0d (R2,R3,R6,R7,R8,R9)", i),
            {ledOut, ifSelPin}, VEC[i][4:0]);
    end

    // R6: synchronizer latency of two edges
    carrierIn = 1'b0;
    writeCfg(4'b0000, 1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R6 settled low", {ledOut, ifSelPin}, 5'b0000_1);
    carrierIn = 1'b1;
    @(negedge clk);
    check("R6 first edge no change", {ledOut, ifSelPin}, 5'b0000_1);
    @(negedge clk);
    check("R6 second edge follows", {ledOut, ifSelPin}, 5'b0001_1);
    carrierIn = 1'b0;
    @(negedge clk);
    check("R6 fall first edge", {ledOut, ifSelPin}, 5'b0001_1);
    @(negedge clk);
    check("R6 fall second edge", {ledOut, ifSelPin}, 5'b0000_1);

    // R10: data changes without strobe are ignored
    writeCfg(4'b0110, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    cfgLedOn = 4'b1001; cfgFlash = 1'b1; cfgCdEnable = 1'b1; cfgIfSel = 1'b0;
    carrierIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 no write held", {ledOut, ifSelPin}, 5'b0110_0);
    carrierIn = 1'b0;

    // R4: blink half-period
    writeCfg(4'b0000, 1'b1, 1'b0, 1'b0);
    measureRun(runLen);
    check("R4 blink run length", 5'(runLen), 5'(HP));
    measureRun(runLen);
    check("R4 blink run length again", 5'(runLen), 5'(HP));

    // R5: blink wins over the carrier mirror, carrier held high then low
    for (int c = 0; c < 2; c++) begin
      carrierIn = (c == 0);
      writeCfg(4'b0000, 1'b1, 1'b1, 1'b0);
      sawHigh = 1'b0; sawLow = 1'b0;
      for (int k = 0; k < 3 * HP; k++) begin
        @(negedge clk);
        if (ledOut[0]) sawHigh = 1'b1; else sawLow = 1'b1;
      end
      check($sformatf("R5 both levels carrier=%0d", c), {3'b0, sawHigh, sawLow}, 5'b00011);
      measureRun(runLen);
      check($sformatf("R5 run length carrier=%0d", c), 5'(runLen), 5'(HP));
    end

    // R3: steady-on overrides an active blink
    writeCfg(4'b0001, 1'b1, 1'b1, 1'b0);
    sawLow = 1'b0;
    for (int k = 0; k < 3 * HP; k++) begin
      @(negedge clk);
      if (!ledOut[0]) sawLow = 1'b1;
    end
    check("R3 steady over blink window", {4'b0, sawLow}, 5'b0);

    // R7 / R8: mirror off, carrier toggling, LED 1 dark
    writeCfg(4'b0000, 1'b0, 1'b0, 1'b0);
    sawHigh = 1'b0;
    for (int k = 0; k < 6; k++) begin
      carrierIn = k[0];
      @(negedge clk);
      if (ledOut[0]) sawHigh = 1'b1;
    end
    check("R7 R8 carrier ignored", {ledOut, sawHigh}, 5'b0000_0);

    // R1: reset again mid-operation
    writeCfg(4'b1111, 1'b1, 1'b1, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reapplied reset", {ledOut, ifSelPin}, 5'b0000_1);
    rstN = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule